// File: doc/BRIEF.md
# Core Memory Cycle Sequencer

This controller times every access to a coincident-current magnetic core store of 4096 twelve-bit words. A CPU presents a read, a write or a read-modify-write request with an address. The controller splits the address into an X index and a Y index. It raises one X select line and one Y select line, first with the current direction that clears the core and then with the direction that sets it. It latches the digitised sense comparator outputs at a programmable delay into the read pulse.

Sensing a core clears it. For that reason every access ends with a write current phase, and in that phase a per-bit inhibit line blocks the bits that must remain zero. A read writes back the word it sensed. A plain write also runs the clearing phase first, ignores what it senses, and then stores the new word. A read-modify-write pauses between the two phases. It holds every select line off until the CPU hands over a replacement word, and that word is stored instead of the sensed one. Drive and recovery lengths come from configuration inputs, so the same logic fits planes and drivers with different switching times.

Top module: `core_cycle_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, ready, done, both phase flags, every select line and every inhibit line are low.
- R2: The X index is address bits 11:6 and the Y index is address bits 5:0. During a current phase exactly one X line (bit X index) and exactly one Y line (bit Y index) are high. Outside a current phase every select line is low.
- R3: The clearing (read) phase starts in the cycle after acceptance and lasts max(strobe delay,1)+1 cycles. The sense inputs are latched at the end of its last cycle.
- R4: For read and read-modify-write accesses, ready is high for exactly one cycle, the cycle that follows the last read-phase cycle, and rdata then equals the latched sense word. A plain write never raises ready.
- R5: The read and write phases never overlap. After the read phase, max(read recovery,1) cycles pass with no select line high before a write phase or the wait state begins.
- R6: During the write phase the inhibit bus equals the bitwise complement of the word being stored. At all other times it is zero.
- R7: A plain write runs the read phase and then stores the request's data word. The sensed value has no effect on what is stored.
- R8: A read-modify-write waits after read recovery with all lines off until rmw_valid is seen high. rmw_valid has no effect at any other time. The write phase starts in the cycle after it is taken and stores rmw_wdata.
- R9: The write phase lasts max(write length,1) cycles and is followed by max(write recovery,1) idle cycles. done is then high for one cycle. busy is high from the cycle after acceptance through the done cycle.
- R10: A request presented while busy is high, including in the done cycle, is ignored and changes no stored word.
- R11: The operation codes are 00 read, 01 write and 10 read-modify-write. Code 11 behaves as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | Operation code |
| req_addr | input | 12 | Word address |
| req_wdata | input | 12 | Data for a plain write |
| rmw_valid | input | 1 | Replacement word is present (read-modify-write) |
| rmw_wdata | input | 12 | Replacement word |
| cfg_strobe_dly | input | 8 | Read drive cycles before the strobe cycle |
| cfg_read_rec | input | 8 | Recovery cycles after the read phase |
| cfg_write_len | input | 8 | Write drive cycles |
| cfg_write_rec | input | 8 | Recovery cycles after the write phase |
| sense | input | 12 | Digitised sense comparator outputs |
| x_sel | output | 64 | X half-select line enables |
| y_sel | output | 64 | Y half-select line enables |
| rd_phase | output | 1 | Clearing-direction current is on |
| wr_phase | output | 1 | Setting-direction current is on |
| inhibit | output | 12 | Per-bit inhibit drivers |
| busy | output | 1 | Access in progress |
| ready | output | 1 | Read data is valid (one cycle) |
| rdata | output | 12 | Latched data word |
| done | output | 1 | Last cycle of the access |

## Verification
Two pairs of events can fall in the same cycle. The done pulse can coincide with a new request, and the first wait cycle of a read-modify-write can coincide with rmw_valid. The bench holds a competing request high through the whole busy window, done cycle included, and asserts rmw_valid both before the wait begins and exactly as it begins. A behavioural plane model and a per-cycle reference compare every output on each clock. The bench then checks that only the intended word changed in the plane.

// File: rtl/core_cycle_seq.sv
module core_cycle_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     rmw_valid,
  input  logic [DATA_W-1:0]        rmw_wdata,
  input  logic [CNT_W-1:0]         cfg_strobe_dly,
  input  logic [CNT_W-1:0]         cfg_read_rec,
  input  logic [CNT_W-1:0]         cfg_write_len,
  input  logic [CNT_W-1:0]         cfg_write_rec,
  input  logic [DATA_W-1:0]        sense,
  output logic [(1<<(ADDR_W/2))-1:0]          x_sel,
  output logic [(1<<(ADDR_W-ADDR_W/2))-1:0]   y_sel,
  output logic                     rd_phase,
  output logic                     wr_phase,
  output logic [DATA_W-1:0]        inhibit,
  output logic                     busy,
  output logic                     ready,
  output logic [DATA_W-1:0]        rdata,
  output logic                     done
);
  localparam int XW = ADDR_W / 2;
  localparam int YW = ADDR_W - XW;
  localparam int XN = 1 << XW;
  localparam int YN = 1 << YW;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RMW = 2'b10;

  typedef enum logic [2:0] {
    IDLE, READ_DRIVE, STROBE, READ_RECOVER, RMW_WAIT, WRITE_DRIVE, WRITE_RECOVER, DONE
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt, len;
  logic [1:0]        op;
  logic [XW-1:0]     xa;
  logic [YW-1:0]     ya;
  logic [DATA_W-1:0] data;
  logic              last;

  always_comb begin
    case (state)
      READ_DRIVE:    len = cfg_strobe_dly;
      READ_RECOVER:  len = cfg_read_rec;
      WRITE_DRIVE:   len = cfg_write_len;
      WRITE_RECOVER: len = cfg_write_rec;
      default:       len = '0;
    endcase
  end

  assign last = ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
      op    <= '0;
      xa    <= '0;
      ya    <= '0;
      data  <= '0;
      ready <= 1'b0;
    end else begin
      ready <= 1'b0;
      cnt   <= cnt + 1'b1;
      case (state)
        IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            op    <= req_op;
            xa    <= req_addr[ADDR_W-1 -: XW];
            ya    <= req_addr[YW-1:0];
            data  <= req_wdata;
            state <= READ_DRIVE;
          end
        end
        READ_DRIVE: if (last) begin state <= STROBE; cnt <= '0; end
        STROBE: begin
          if (op != OP_WR) begin
            data  <= sense;
            ready <= 1'b1;
          end
          state <= READ_RECOVER;
          cnt   <= '0;
        end
        READ_RECOVER: if (last) begin
          state <= (op == OP_RMW) ? RMW_WAIT : WRITE_DRIVE;
          cnt   <= '0;
        end
        RMW_WAIT: begin
          cnt <= '0;
          if (rmw_valid) begin
            data  <= rmw_wdata;
            state <= WRITE_DRIVE;
          end
        end
        WRITE_DRIVE:   if (last) begin state <= WRITE_RECOVER; cnt <= '0; end
        WRITE_RECOVER: if (last) begin state <= DONE; cnt <= '0; end
        default:       state <= IDLE;
      endcase
    end
  end

  assign rd_phase = (state == READ_DRIVE) || (state == STROBE);
  assign wr_phase = (state == WRITE_DRIVE);
  assign x_sel    = (rd_phase || wr_phase) ? (XN'(1) << xa) : '0;
  assign y_sel    = (rd_phase || wr_phase) ? (YN'(1) << ya) : '0;
  assign inhibit  = wr_phase ? ~data : '0;
  assign busy     = (state != IDLE);
  assign done     = (state == DONE);
  assign rdata    = data;

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_phase && wr_phase));
  a_r5_gap_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_phase) |-> !$past(rd_phase));
  a_r2_single_x: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase || wr_phase) |-> ($countones(x_sel) == 1 && $countones(y_sel) == 1));
  a_r6_inhibit_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit != '0) |-> wr_phase);
  a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: tb/core_cycle_seq_test.sv
module core_cycle_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [11:0] req_addr = '0, req_wdata = '0;
  logic        rmw_valid = 1'b0;
  logic [11:0] rmw_wdata = '0;
  logic [7:0]  cfg_strobe_dly = 8'd2, cfg_read_rec = 8'd1, cfg_write_len = 8'd2, cfg_write_rec = 8'd1;
  logic [11:0] sense = '0;
  logic [63:0] x_sel, y_sel;
  logic        rd_phase, wr_phase, busy, ready, done;
  logic [11:0] inhibit, rdata;

  core_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rmw_valid(rmw_valid),
    .rmw_wdata(rmw_wdata), .cfg_strobe_dly(cfg_strobe_dly), .cfg_read_rec(cfg_read_rec),
    .cfg_write_len(cfg_write_len), .cfg_write_rec(cfg_write_rec), .sense(sense),
    .x_sel(x_sel), .y_sel(y_sel), .rd_phase(rd_phase), .wr_phase(wr_phase),
    .inhibit(inhibit), .busy(busy), .ready(ready), .rdata(rdata), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural core plane
  logic [11:0] plane [int];
  logic [11:0] exp_mem [int];
  bit   prev_rd = 0;
  int   last_a = 0;

  function automatic int first_bit(input logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [11:0] peek(input int a);
    return plane.exists(a) ? plane[a] : 12'h000;
  endfunction

  function automatic logic [11:0] mpeek(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : 12'h000;
  endfunction

  always @(negedge clk) begin
    int a;
    a = first_bit(x_sel) * 64 + first_bit(y_sel);
    if (prev_rd && !rd_phase) plane[last_a] = 12'h000;
    if (rd_phase) last_a = a;
    if (wr_phase) plane[a] = ~inhibit;
    sense <= rd_phase ? peek(a) : 12'h000;
    prev_rd = rd_phase;
  end

  // reference model
  bit          m_busy = 0;
  int          acc = 0, ws = -1, m_d, m_r, m_w, m_q;
  logic [1:0]  m_op;
  int          m_a;
  logic [11:0] m_pre, m_wdat;

  function automatic int atl1(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk) begin
    bit was_busy;
    int n;
    was_busy = m_busy;
    n = cyc - acc + 1;
    if (!rst_n) begin
      m_busy = 0;
    end else begin
      if (m_busy && m_op == 2'b10 && ws < 0 && n >= m_d + 2 + m_r && rmw_valid) begin
        ws = n + 1;
        m_wdat = rmw_wdata;
        exp_mem[m_a] = rmw_wdata;
      end
      if (m_busy && ws > 0 && n == ws + m_w + m_q) m_busy = 0;
      if (!was_busy && req_valid) begin
        m_busy = 1;
        acc = cyc + 1;
        m_op = req_op;
        m_a = int'(req_addr);
        m_d = atl1(cfg_strobe_dly); m_r = atl1(cfg_read_rec);
        m_w = atl1(cfg_write_len);  m_q = atl1(cfg_write_rec);
        m_pre = mpeek(m_a);
        if (req_op == 2'b01) begin m_wdat = req_wdata; exp_mem[m_a] = req_wdata; end
        else m_wdat = m_pre;
        ws = (req_op == 2'b10) ? -1 : m_d + 2 + m_r;
      end
    end
    cyc++;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int n;
    bit e_rd, e_wr, e_rdy, e_done;
    logic [63:0] e_x, e_y;
    logic [11:0] e_inh;
    n = cyc - acc + 1;
    if (rst_n) begin
      e_rd   = m_busy && n >= 1 && n <= m_d + 1;
      e_wr   = m_busy && ws > 0 && n >= ws && n < ws + m_w;
      e_rdy  = m_busy && n == m_d + 2 && m_op != 2'b01;
      e_done = m_busy && ws > 0 && n == ws + m_w + m_q;
      e_x    = (e_rd || e_wr) ? (64'd1 << (m_a / 64)) : 64'd0;
      e_y    = (e_rd || e_wr) ? (64'd1 << (m_a % 64)) : 64'd0;
      e_inh  = e_wr ? ~m_wdat : 12'h000;
      chk(busy == m_busy, "R9 busy", 64'(busy), 64'(m_busy));
      chk(x_sel == e_x, "R2 x_sel", x_sel, e_x);
      chk(y_sel == e_y, "R2 y_sel", y_sel, e_y);
      chk(rd_phase == e_rd, "R3 rd_phase", 64'(rd_phase), 64'(e_rd));
      chk(wr_phase == e_wr, "R5 wr_phase", 64'(wr_phase), 64'(e_wr));
      chk(inhibit == e_inh, "R6 inhibit", 64'(inhibit), 64'(e_inh));
      chk(ready == e_rdy, "R4 ready", 64'(ready), 64'(e_rdy));
      if (e_rdy) chk(rdata == m_pre, "R4 rdata", 64'(rdata), 64'(m_pre));
      chk(done == e_done, "R9 done", 64'(done), 64'(e_done));
    end
  end

  task automatic issue(input logic [1:0] op, input logic [11:0] a, input logic [11:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic plane_chk(input int a, input string tag);
    chk(peek(a) == mpeek(a), tag, 64'(peek(a)), 64'(mpeek(a)));
  endtask

  task automatic do_rmw(input logic [11:0] a, input logic [11:0] d, input int dly, input bit early);
    issue(2'b10, a, 12'h000);
    rmw_wdata = d;
    if (early) rmw_valid = 1;
    repeat (dly) @(negedge clk);
    rmw_valid = 1;
    wait_idle();
    rmw_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !ready && !done && !rd_phase && !wr_phase, "R1 flags", 64'({busy, ready, done, rd_phase, wr_phase}), 64'd0);
    chk(x_sel == 0 && y_sel == 0 && inhibit == 0, "R1 lines", x_sel | y_sel, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && x_sel == 0, "R1 after release", 64'(busy), 64'd0);

    // R7: plain writes store data; the sensed value is discarded
    issue(2'b01, 12'hABC, 12'h5A3); wait_idle(); plane_chk(12'hABC, "R7 plane");
    issue(2'b01, 12'h041, 12'hFFF); wait_idle(); plane_chk(12'h041, "R7 plane all ones");
    issue(2'b01, 12'hABC, 12'h0C0); wait_idle(); plane_chk(12'hABC, "R7 overwrite");
    // R3/R4: reads restore
    issue(2'b00, 12'hABC, 12'h000); wait_idle(); plane_chk(12'hABC, "R3 restore");
    issue(2'b00, 12'h041, 12'h000); wait_idle(); plane_chk(12'h041, "R4 restore ones");
    // R11: code 11 acts as a read
    issue(2'b11, 12'h041, 12'h123); wait_idle(); plane_chk(12'h041, "R11 code 11 read");

    // zero-length timing values act as one cycle
    cfg_strobe_dly = 0; cfg_read_rec = 0; cfg_write_len = 0; cfg_write_rec = 0;
    issue(2'b01, 12'h000, 12'h001); wait_idle(); plane_chk(12'h000, "R5 min timing");
    issue(2'b00, 12'h000, 12'h000); wait_idle();
    // longer timing
    cfg_strobe_dly = 5; cfg_read_rec = 3; cfg_write_len = 4; cfg_write_rec = 2;
    issue(2'b01, 12'hFFF, 12'h800); wait_idle(); plane_chk(12'hFFF, "R9 long timing");
    issue(2'b00, 12'hFFF, 12'h000); wait_idle();

    // R8: read-modify-write, late and immediate replacement
    do_rmw(12'hABC, 12'h777, 20, 0); plane_chk(12'hABC, "R8 rmw late");
    do_rmw(12'h041, 12'h002, 0, 1);  plane_chk(12'h041, "R8 rmw early valid");
    cfg_strobe_dly = 1; cfg_read_rec = 1; cfg_write_len = 1; cfg_write_rec = 1;
    do_rmw(12'h7C3, 12'hFFE, 3, 0);  plane_chk(12'h7C3, "R8 rmw new word");

    // R10: competing request held through busy and done
    @(negedge clk);
    req_valid = 1; req_op = 2'b01; req_addr = 12'h555; req_wdata = 12'h3C3;
    @(negedge clk);
    req_addr = 12'h666; req_wdata = 12'hEEE;
    wait_idle();
    req_valid = 0;
    @(negedge clk);
    plane_chk(12'h666, "R10 ignored request");
    plane_chk(12'h555, "R10 accepted request");
    issue(2'b00, 12'h555, 12'h000); wait_idle();
    issue(2'b00, 12'h7C3, 12'h000); wait_idle(); plane_chk(12'h7C3, "R8 readback");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule